// File: doc/BRIEF.md
# Interleaved Thread Issue Scheduler with Cycle Stealing

This block decides, in every clock cycle, which of up to eight hardware threads may issue one instruction into a thread-interleaved pipeline. A rotating table of slots sets the schedule. Each slot is assigned to one thread, shared by all soft threads, or switched off. A hard real-time thread that is ready always receives the slots it owns. No other thread can take them, so its share of the issue cycles is fixed by the number of slots it holds. For example, two of four slots give it one cycle in two.

A cycle is not wasted when its owner cannot use it. The owner may be a hard thread that is waiting for a time, sleeping or finished, or a soft thread that is not ready. Such a cycle, and every shared slot, goes to the ready soft threads in round-robin order. When no thread can take the cycle, the scheduler emits a bubble. A new table, or a new table length, loads only when the rotation wraps. The schedule therefore never runs half old and half new.

Top module: `ilv_sched_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, issue_valid_o is low. The table supplied at that time loads at the end of that first cycle, and the rotation starts at its first enabled slot.
- R2: Slot i of the table is the 4-bit field slot_cfg_i[4i+3:4i]. Codes 0 to 7 give the slot to that thread. Code 8 makes it a shared soft slot. Codes 9 to 15 disable it. The table length is slot_last_i+1. Slots are visited in ascending index and the rotation wraps after the last one.
- R3: In a slot owned by a ready hard thread (mode code 2'b01 in thr_mode_i[2t+1:2t]), that thread issues. Its issue rate therefore equals the fraction of slots it owns.
- R4: If the owner of a slot is a hard thread that is not ready, the cycle goes to a ready soft thread (mode code 2'b10).
- R5: Shared slots, and cycles not used by their owner, are granted round-robin among the ready soft threads. The search starts at the round-robin pointer. After reset the pointer is thread 0.
- R6: After each round-robin grant, the pointer moves to the thread one past the granted thread.
- R7: If no eligible thread is ready, issue_valid_o is low for that cycle.
- R8: A disabled slot takes no cycle; the rotation goes directly to the next enabled slot.
- R9: A change to slot_cfg_i or slot_last_i takes effect only after the last slot of the running rotation has been used.
- R10: A ready soft thread that owns a slot issues in it. Such a grant does not move the round-robin pointer. A slot whose owner is inactive (mode 2'b00 or 2'b11) is handled like a not-ready owner.
- R11: A hard thread issues only in a slot that it owns. It never takes a shared slot or a slot left unused by another thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_cfg_i | input | 32 | Slot table, 4-bit code per slot |
| slot_last_i | input | 3 | Index of the last slot in the rotation |
| thr_mode_i | input | 16 | Per-thread mode, 2 bits each |
| thr_ready_i | input | 8 | Per-thread ready flag |
| issue_tid_o | output | 3 | Selected thread |
| issue_valid_o | output | 1 | A thread issues this cycle |

## Verification
The assertions assume three things. A thread's mode and ready flag are stable for the whole cycle in which they are sampled. Thread IDs in the table refer to real threads. The table is not checked for consistency beyond the disabled code. The bench changes mode and ready only between clock edges, away from sampling. It writes only the documented slot codes. It changes the table in the middle of a rotation only in the test of deferred loading.

// File: rtl/ilv_sched_pkg.sv
// Shared constants for the interleaved issue scheduler.
// Assumes thread count is a power of two so a slot code's top bit marks non-thread codes.
package ilv_sched_pkg;
    localparam int unsigned TID_W  = 3;
    localparam int unsigned CODE_W = TID_W + 1;
    localparam logic [CODE_W-1:0] CODE_POOL = CODE_W'(1 << TID_W);
    localparam logic [CODE_W-1:0] CODE_OFF  = '1;

    typedef enum logic [1:0] {
        MODE_IDLE0 = 2'b00,
        MODE_HARD  = 2'b01,
        MODE_SOFT  = 2'b10,
        MODE_IDLE1 = 2'b11
    } thr_mode_e;
endpackage

// File: rtl/ilv_slot_seq.sv
// Slot rotation: keeps the active copy of the slot table and a pointer to the
// current enabled slot. Loads a new table only at wrap. Assumes NS >= 2.
module ilv_slot_seq
    import ilv_sched_pkg::*;
#(
    parameter int unsigned NS = 8,
    localparam int unsigned SW = $clog2(NS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NS*CODE_W-1:0] cfg_i,
    input  logic [SW-1:0]        last_i,
    output logic [CODE_W-1:0]    cur_code_o,
    output logic                 wrap_o
);
    logic [CODE_W-1:0] tbl_q [NS];
    logic [SW-1:0]     last_q;
    logic [SW-1:0]     ptr_q;
    logic [SW-1:0]     adv_idx;
    logic [SW-1:0]     first_idx;
    logic              adv_found;

    // Current slot code seen by the issue logic.
    assign cur_code_o = tbl_q[ptr_q];

    // Next enabled slot after the pointer in the running table.
    always_comb begin
        adv_found = 1'b0;
        adv_idx   = '0;
        for (int i = 0; i < NS; i++) begin
            if (!adv_found && SW'(i) > ptr_q && SW'(i) <= last_q && tbl_q[i] != CODE_OFF
                && tbl_q[i] <= CODE_POOL) begin
                adv_found = 1'b1;
                adv_idx   = SW'(i);
            end
        end
    end

    // First enabled slot of the incoming table, used on wrap.
    always_comb begin
        first_idx = '0;
        for (int i = NS - 1; i >= 0; i--) begin
            if (SW'(i) <= last_i && cfg_i[i*CODE_W +: CODE_W] <= CODE_POOL)
                first_idx = SW'(i);
        end
    end

    assign wrap_o = !adv_found;

    // Advance the pointer; on wrap take the new table and length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NS; i++) tbl_q[i] <= CODE_OFF;
            last_q <= '0;
            ptr_q  <= '0;
        end else if (wrap_o) begin
            for (int i = 0; i < NS; i++) tbl_q[i] <= cfg_i[i*CODE_W +: CODE_W];
            last_q <= last_i;
            ptr_q  <= first_idx;
        end else begin
            ptr_q <= adv_idx;
        end
    end
endmodule

// File: rtl/ilv_soft_rr.sv
// Round-robin picker over ready soft threads. Search starts at the pointer;
// the pointer moves one past the picked thread when take_i is high.
module ilv_soft_rr
    import ilv_sched_pkg::*;
#(
    parameter int unsigned NT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NT-1:0]    cand_i,
    input  logic             take_i,
    output logic             pick_valid_o,
    output logic [TID_W-1:0] pick_tid_o
);
    logic [TID_W-1:0] rr_q;

    // Find the first candidate at or after the pointer, cyclically.
    always_comb begin
        pick_valid_o = 1'b0;
        pick_tid_o   = '0;
        for (int k = 0; k < NT; k++) begin
            int idx;
            idx = int'(rr_q) + k;
            if (idx >= NT) idx = idx - NT;
            if (!pick_valid_o && cand_i[idx]) begin
                pick_valid_o = 1'b1;
                pick_tid_o   = TID_W'(idx);
            end
        end
    end

    // Move the pointer past each granted thread.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rr_q <= '0;
        else if (take_i && pick_valid_o)
            rr_q <= (int'(pick_tid_o) == NT - 1) ? '0 : pick_tid_o + 1'b1;
    end
endmodule

// File: rtl/ilv_sched_top.sv
// Issue scheduler top: per cycle gives the slot to its ready owner, otherwise
// to a round-robin soft thread, otherwise a bubble. Hard threads only ever
// issue in their own slots. Assumes NT = 2**TID_W.
module ilv_sched_top
    import ilv_sched_pkg::*;
#(
    parameter int unsigned NT = 8,
    parameter int unsigned NS = 8,
    localparam int unsigned SW = $clog2(NS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NS*CODE_W-1:0] slot_cfg_i,
    input  logic [SW-1:0]        slot_last_i,
    input  logic [NT*2-1:0]      thr_mode_i,
    input  logic [NT-1:0]        thr_ready_i,
    output logic [TID_W-1:0]     issue_tid_o,
    output logic                 issue_valid_o
);
    logic [CODE_W-1:0] cur_code;
    logic              wrap;
    logic [NT-1:0]     is_hard;
    logic [NT-1:0]     is_soft;
    logic              pick_valid;
    logic [TID_W-1:0]  pick_tid;
    logic              rr_take;
    logic [TID_W-1:0]  owner;
    logic              owner_go;
    logic              slot_live;

    // Per-thread mode decode.
    generate
        for (genvar t = 0; t < NT; t++) begin : g_mode
            assign is_hard[t] = thr_mode_i[2*t +: 2] == MODE_HARD;
            assign is_soft[t] = thr_mode_i[2*t +: 2] == MODE_SOFT;
        end
    endgenerate

    ilv_slot_seq #(.NS(NS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_i      (slot_cfg_i),
        .last_i     (slot_last_i),
        .cur_code_o (cur_code),
        .wrap_o     (wrap)
    );

    ilv_soft_rr #(.NT(NT)) u_rr (
        .clk          (clk),
        .rst_n        (rst_n),
        .cand_i       (is_soft & thr_ready_i),
        .take_i       (rr_take),
        .pick_valid_o (pick_valid),
        .pick_tid_o   (pick_tid)
    );

    // Owner check of the current slot.
    assign owner     = cur_code[TID_W-1:0];
    assign slot_live = cur_code <= CODE_POOL;
    assign owner_go  = (cur_code < CODE_POOL) && thr_ready_i[owner]
                       && (is_hard[owner] || is_soft[owner]);

    // Issue selection: owner first, then a stolen or shared soft grant.
    always_comb begin
        issue_valid_o = 1'b0;
        issue_tid_o   = '0;
        rr_take       = 1'b0;
        if (owner_go) begin
            issue_valid_o = 1'b1;
            issue_tid_o   = owner;
        end else if (slot_live) begin
            issue_valid_o = pick_valid;
            issue_tid_o   = pick_tid;
            rr_take       = pick_valid;
        end
    end
endmodule

// File: rtl/ilv_sched_chk.sv
// Checker for the issue scheduler, bound into the top. Assumes inputs are
// stable within a cycle.
module ilv_sched_chk
    import ilv_sched_pkg::*;
#(
    parameter int unsigned NT = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NT*2-1:0]   thr_mode_i,
    input logic [NT-1:0]     thr_ready_i,
    input logic [TID_W-1:0]  issue_tid_o,
    input logic              issue_valid_o,
    input logic [CODE_W-1:0] cur_code,
    input logic              wrap
);
    logic [NT-1:0] soft_rdy;
    logic [1:0]    sel_mode;
    logic [1:0]    own_mode;
    always_comb begin
        for (int t = 0; t < NT; t++)
            soft_rdy[t] = thr_ready_i[t] && thr_mode_i[2*t +: 2] == MODE_SOFT;
        sel_mode = thr_mode_i[2*issue_tid_o +: 2];
        own_mode = thr_mode_i[2*cur_code[TID_W-1:0] +: 2];
    end

    // R7: whatever issues is ready and active
    p_issue_eligible_r7: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid_o |-> thr_ready_i[issue_tid_o]
                          && (sel_mode == MODE_HARD || sel_mode == MODE_SOFT));

    // R3: ready hard owner always gets its slot
    p_hard_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_code < CODE_POOL && own_mode == MODE_HARD && thr_ready_i[cur_code[TID_W-1:0]])
        |-> issue_valid_o && issue_tid_o == cur_code[TID_W-1:0]);

    // R11: hard thread issues only in its own slot
    p_hard_own_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid_o && sel_mode == MODE_HARD) |-> cur_code == {1'b0, issue_tid_o});

    // R4: idle hard slot is stolen by a ready soft thread
    p_steal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_code < CODE_POOL && own_mode == MODE_HARD
         && !thr_ready_i[cur_code[TID_W-1:0]] && |soft_rdy)
        |-> issue_valid_o && sel_mode == MODE_SOFT);

    // R5: shared slot is used when any soft thread is ready
    p_pool_used_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_code == CODE_POOL && |soft_rdy) |-> issue_valid_o);

    // R8: a disabled code is never the running slot while another exists
    p_off_bubble_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_code > CODE_POOL) |-> !issue_valid_o && wrap);
endmodule

bind ilv_sched_top ilv_sched_chk #(.NT(NT)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .thr_mode_i    (thr_mode_i),
    .thr_ready_i   (thr_ready_i),
    .issue_tid_o   (issue_tid_o),
    .issue_valid_o (issue_valid_o),
    .cur_code      (cur_code),
    .wrap          (wrap)
);

// File: tb/tb_ilv_sched_top.sv
// Directed bench for the issue scheduler; each task checks its own scenario.
module tb_ilv_sched_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] slot_cfg_i = '1;
    logic [2:0]  slot_last_i = '0;
    logic [15:0] thr_mode_i = '0;
    logic [7:0]  thr_ready_i = '0;
    logic [2:0]  issue_tid_o;
    logic        issue_valid_o;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ilv_sched_top dut (
        .clk(clk), .rst_n(rst_n), .slot_cfg_i(slot_cfg_i), .slot_last_i(slot_last_i),
        .thr_mode_i(thr_mode_i), .thr_ready_i(thr_ready_i),
        .issue_tid_o(issue_tid_o), .issue_valid_o(issue_valid_o)
    );

    function automatic logic [31:0] tbl(input logic [3:0] s0, s1, s2, s3,
                                        input logic [3:0] s4, s5, s6, s7);
        return {s7, s6, s5, s4, s3, s2, s1, s0};
    endfunction

    function automatic void set_mode(input int t, input logic [1:0] m);
        thr_mode_i[2*t +: 2] = m;
    endfunction

    // Check the current cycle, then step to the next one.
    task automatic cyc(input bit ev, input logic [2:0] et, input string req);
        #1;
        checks++;
        if (issue_valid_o !== ev || (ev && issue_tid_o !== et)) begin
            errors++;
            $display("FAIL %s: got valid=%0b tid=%0d, expected valid=%0b tid=%0d",
                     req, issue_valid_o, issue_tid_o, ev, et);
        end
        @(posedge clk); #1;
    endtask

    // Reset with the prepared inputs; cycle 0 after release is a bubble.
    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk); #1;
        cyc(1'b0, 3'd0, "R1 in reset");
        rst_n = 1'b1;
        cyc(1'b0, 3'd0, "R1 first cycle");
    endtask

    task automatic t_rates();
        slot_cfg_i = tbl(4'd0, 4'd1, 4'd0, 4'd2, 4'hF, 4'hF, 4'hF, 4'hF);
        slot_last_i = 3'd3;
        thr_mode_i = '0; set_mode(0, 2'b01); set_mode(1, 2'b01); set_mode(2, 2'b10);
        thr_ready_i = 8'b0000_0111;
        do_reset();
        for (int r = 0; r < 2; r++) begin
            cyc(1'b1, 3'd0, "R3 A slot"); cyc(1'b1, 3'd1, "R3 B slot");
            cyc(1'b1, 3'd0, "R2 A slot"); cyc(1'b1, 3'd2, "R10 C slot");
        end
    endtask

    task automatic t_steal();
        thr_ready_i = 8'b0000_0101;
        do_reset();
        for (int r = 0; r < 2; r++) begin
            cyc(1'b1, 3'd0, "R3 A slot"); cyc(1'b1, 3'd2, "R4 stolen B slot");
            cyc(1'b1, 3'd0, "R3 A slot"); cyc(1'b1, 3'd2, "R10 C slot");
        end
    endtask

    task automatic t_pool();
        slot_cfg_i = tbl(4'd8, 4'd8, 4'd8, 4'd8, 4'hF, 4'hF, 4'hF, 4'hF);
        slot_last_i = 3'd3;
        thr_mode_i = '0; set_mode(3, 2'b10); set_mode(5, 2'b10); set_mode(6, 2'b10);
        set_mode(0, 2'b01);
        thr_ready_i = 8'b0110_1001;
        do_reset();
        cyc(1'b1, 3'd3, "R5 pool"); cyc(1'b1, 3'd5, "R6 rr");
        cyc(1'b1, 3'd6, "R6 rr"); cyc(1'b1, 3'd3, "R6 rr wrap");
        thr_ready_i = '0;
        cyc(1'b0, 3'd0, "R7 none ready");
        thr_ready_i = 8'b0000_0001;
        cyc(1'b0, 3'd0, "R11 hard skips pool");
    endtask

    task automatic t_disabled();
        slot_cfg_i = tbl(4'hF, 4'd0, 4'hC, 4'd1, 4'hF, 4'hF, 4'hF, 4'hF);
        slot_last_i = 3'd3;
        thr_mode_i = '0; set_mode(0, 2'b01); set_mode(1, 2'b01);
        thr_ready_i = 8'b0000_0011;
        do_reset();
        for (int r = 0; r < 3; r++) begin
            cyc(1'b1, 3'd0, "R8 skip off"); cyc(1'b1, 3'd1, "R8 skip off");
        end
        thr_ready_i = 8'b0000_0001;
        cyc(1'b1, 3'd0, "R3 A slot"); cyc(1'b0, 3'd0, "R7 owner idle no soft");
    endtask

    task automatic t_deferred();
        slot_cfg_i = tbl(4'd0, 4'd1, 4'd0, 4'd2, 4'hF, 4'hF, 4'hF, 4'hF);
        slot_last_i = 3'd3;
        thr_mode_i = '0; set_mode(0, 2'b01); set_mode(1, 2'b01); set_mode(2, 2'b10);
        set_mode(3, 2'b01);
        thr_ready_i = 8'b0000_1111;
        do_reset();
        cyc(1'b1, 3'd0, "R9 old"); cyc(1'b1, 3'd1, "R9 old");
        slot_cfg_i = tbl(4'd3, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF);
        slot_last_i = 3'd0;
        cyc(1'b1, 3'd0, "R9 old kept"); cyc(1'b1, 3'd2, "R9 old kept");
        cyc(1'b1, 3'd3, "R9 new"); cyc(1'b1, 3'd3, "R9 new");
    endtask

    task automatic t_soft_owner();
        slot_cfg_i = tbl(4'd2, 4'd8, 4'd4, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF);
        slot_last_i = 3'd2;
        thr_mode_i = '0; set_mode(2, 2'b10); set_mode(5, 2'b10); set_mode(4, 2'b11);
        thr_ready_i = 8'b0011_0100;
        do_reset();
        cyc(1'b1, 3'd2, "R10 soft owner"); cyc(1'b1, 3'd2, "R5 pool rr0");
        cyc(1'b1, 3'd5, "R10 inactive owner stolen");
        cyc(1'b1, 3'd2, "R10 owner no rr move"); cyc(1'b1, 3'd2, "R6 rr past 5");
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(posedge clk); #1;
        t_rates();
        t_steal();
        t_pool();
        t_disabled();
        t_deferred();
        t_soft_owner();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule